// File: doc/BRIEF.md
# Circular Seed Rotation Expander

This block turns one 64-bit seed word into all 64 of its cyclic rotations in a single cycle and marks which of them are worth passing on. Downstream search stages treat every rotation of a seed as a separate candidate code. A seed arrives on a valid/ready input. One registered output stage carries a wide vector of 64 lanes and a per-lane valid mask. That stage is handed on over a second valid/ready pair.

Rotation leaves the number of ones unchanged, so the seed's weight is counted once. The pass/fail result of that count is shared by every lane. A seed passes when its weight leaves the configured residue modulo 4 and also reaches the configured minimum. A seed that repeats itself under rotation would produce identical lanes, so only the first copy of each distinct pattern is kept in the mask. Back-pressure works as follows. While the output holds unconsumed data and `out_ready` is low, the output stays frozen and `in_ready` is low. A new seed is accepted in any cycle in which the output stage is empty or is being drained, which gives one seed per cycle when `out_ready` stays high.

Top module: `seed_rot_expander`

## Requirements
- R1: A seed presented with `in_valid` while `in_ready` is high appears on the outputs on the next rising edge, with `out_valid` high.
- R2: While `out_valid` is high and `out_ready` is low, `out_lanes` and `out_mask` do not change, `out_valid` stays high and `in_ready` is low, so no second seed is accepted.
- R3: Lane i occupies `out_lanes[i*64 +: 64]` and holds the seed rotated right by i. Bit j of lane i equals seed bit (j+i) mod 64, and seed bit 0 is the first code position. Lane 0 is the seed itself.
- R4: A seed qualifies only if its count of ones modulo 4 equals `WT_RES` (default 3). For example, a seed with 20 ones gets an all-zero mask under the defaults.
- R5: A seed qualifies only if its count of ones is at least `MIN_WT` (default 19). A seed with 19 ones and residue 3 gets all 64 mask bits set, and one with 18 ones gets none.
- R6: For a qualifying seed whose smallest rotation period is p, mask bits 0 to p-1 are set and the rest are clear. This means only the first occurrence of each distinct lane pattern is marked.
- R7: An all-zero seed is still emitted with `out_valid` high, and its mask is all zero.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: Once the output is taken (`out_valid` and `out_ready` both high) and no seed is accepted in that cycle, `out_valid` is low after the edge.
- R10: With `out_ready` held high, seeds are accepted on consecutive cycles, and each appears on the output one cycle after its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Seed word is valid |
| in_ready | output | 1 | Block can accept a seed this cycle |
| in_seed | input | 64 | Seed word, bit 0 is the first code position |
| out_valid | output | 1 | Output vector holds an expanded seed |
| out_ready | input | 1 | Consumer takes the output vector this cycle |
| out_lanes | output | 4096 | 64 lanes of 64 bits, lane i at bits i*64 upward |
| out_mask | output | 64 | Per-lane valid flag |

## Verification
On every cycle, assertions check four things. The output is frozen under back-pressure. An accepted seed fills the output. Lane 1 is lane 0 rotated by one. Any marked lane 0 obeys the residue and minimum-weight rules. They also check that the mask is always a contiguous run from lane 0, and that a zero seed is never marked. Some properties are visible only from the bench's scenarios: the exact length of the mask for periodic seeds, the weight boundaries at 18/19 and 20/23, and the full rotation content of every lane. These rely on known seeds. A second instance with residue 0 is needed, because under the default odd residue no periodic seed can qualify.

// File: rtl/seedrot_pkg.sv
package seedrot_pkg;
  localparam int unsigned SR_W_DEFAULT   = 64;
  localparam int unsigned SR_MINWT_DEF   = 19;
  localparam int unsigned SR_RES_DEF     = 3;

  // rotate right by a constant amount: bit j of result = bit (j+k) mod W
  function automatic logic [SR_W_DEFAULT-1:0] sr_rotr64(input logic [SR_W_DEFAULT-1:0] v,
                                                        input int unsigned k);
    logic [SR_W_DEFAULT-1:0] r;
    for (int j = 0; j < SR_W_DEFAULT; j++) r[j] = v[(j + k) % SR_W_DEFAULT];
    return r;
  endfunction
endpackage

// File: rtl/sr_weight_qual.sv
module sr_weight_qual #(
  parameter int unsigned W      = 64,
  parameter int unsigned MIN_WT = 19,
  parameter int unsigned WT_RES = 3
) (
  input  logic [W-1:0] seed,
  output logic         pass
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] weight;

  always_comb begin
    weight = '0;
    for (int b = 0; b < W; b++) weight = weight + CW'(seed[b]);
  end

  always_comb begin
    pass = ((int'(weight) % 4) == int'(WT_RES)) && (int'(weight) >= int'(MIN_WT));
  end
endmodule

// File: rtl/sr_rotator.sv
module sr_rotator #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]   seed,
  output logic [W*W-1:0] lanes
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    for (genvar j = 0; j < W; j++) begin : g_bit
      assign lanes[i*W + j] = seed[(j + i) % W];
    end
  end
endmodule

// File: rtl/sr_period_mask.sv
module sr_period_mask #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]   seed,
  input  logic [W*W-1:0] lanes,
  output logic [W-1:0]   first
);
  logic [W-1:0] self_match;
  logic [W-1:0] seen;

  assign self_match[0] = 1'b0;
  for (genvar i = 1; i < W; i++) begin : g_cmp
    assign self_match[i] = (lanes[i*W +: W] == seed);
  end

  // a lane repeats an earlier one once any rotation up to it matched the seed
  assign seen[0] = 1'b0;
  for (genvar i = 1; i < W; i++) begin : g_pref
    assign seen[i] = seen[i-1] | self_match[i];
  end

  assign first = ~seen;
endmodule

// File: rtl/seed_rot_expander.sv
module seed_rot_expander #(
  parameter int unsigned W      = seedrot_pkg::SR_W_DEFAULT,
  parameter int unsigned MIN_WT = seedrot_pkg::SR_MINWT_DEF,
  parameter int unsigned WT_RES = seedrot_pkg::SR_RES_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_seed,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W*W-1:0] out_lanes,
  output logic [W-1:0]   out_mask
);
  localparam int unsigned LW = W * W;

  logic [LW-1:0] rot_lanes;
  logic [W-1:0]  first_mask;
  logic          seed_pass;
  logic          accept;

  sr_rotator #(.W(W)) u_rot (
    .seed  (in_seed),
    .lanes (rot_lanes)
  );

  sr_period_mask #(.W(W)) u_per (
    .seed  (in_seed),
    .lanes (rot_lanes),
    .first (first_mask)
  );

  sr_weight_qual #(.W(W), .MIN_WT(MIN_WT), .WT_RES(WT_RES)) u_wq (
    .seed (in_seed),
    .pass (seed_pass)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lanes <= '0;
      out_mask  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_lanes <= rot_lanes;
      out_mask  <= seed_pass ? first_mask : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_lanes) && $stable(out_mask));

  assert_rot1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lanes[2*W-1:W] == {out_lanes[0], out_lanes[W-1:1]});

  assert_residue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mask[0] |-> ($countones(out_lanes[W-1:0]) % 4) == int'(WT_RES));

  assert_minwt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mask[0] |-> $countones(out_lanes[W-1:0]) >= int'(MIN_WT));

  assert_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_mask + W'(1)) & out_mask) == '0);

  assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_lanes[W-1:0] == '0) |-> out_mask == '0);
endmodule

// File: tb/tb_seed_rot_expander.sv
module tb_seed_rot_expander;
  localparam int W = 64;

  typedef struct packed {
    logic [63:0] seed;
    logic [7:0]  cnt_a;   // expected lanes, residue 3 / min 19
    logic [7:0]  cnt_b;   // expected lanes, residue 0 / min 4
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0000_0000, 8'd0,  8'd0 },  // R7 zero seed
    '{64'h0000_0000_0000_0007, 8'd0,  8'd0 },  // weight 3 below minimum
    '{64'h0000_0000_0007_FFFF, 8'd64, 8'd0 },  // weight 19 boundary
    '{64'h0000_0000_0003_FFFF, 8'd0,  8'd0 },  // weight 18
    '{64'h0000_0000_007F_FFFF, 8'd64, 8'd0 },  // weight 23
    '{64'h0000_0000_003F_FFFF, 8'd0,  8'd0 },  // weight 22
    '{64'hFFFF_FFFF_FFFF_FFFF, 8'd0,  8'd1 },  // weight 64, period 1
    '{64'h7FFF_FFFF_FFFF_FFFF, 8'd64, 8'd0 },  // weight 63
    '{64'hA5A5_0000_0000_F0F7, 8'd64, 8'd0 },  // scattered weight 19
    '{64'h5555_5555_5555_5555, 8'd0,  8'd2 },  // period 2
    '{64'h3333_3333_3333_3333, 8'd0,  8'd4 },  // period 4
    '{64'h0000_000F_0000_000F, 8'd0,  8'd32},  // period 32
    '{64'h0000_0000_0000_000F, 8'd0,  8'd64},  // weight 4
    '{64'h0000_0000_0000_FFFF, 8'd0,  8'd64},  // weight 16
    '{64'h0000_0000_000F_FFFF, 8'd0,  8'd64}   // weight 20, R4 residue reject
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [W-1:0] in_seed = '0;
  logic in_ready_a, in_ready_b, out_valid_a, out_valid_b;
  logic [W*W-1:0] lanes_a, lanes_b;
  logic [W-1:0] mask_a, mask_b;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  seed_rot_expander dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_a),
    .in_seed(in_seed), .out_valid(out_valid_a), .out_ready(out_ready),
    .out_lanes(lanes_a), .out_mask(mask_a)
  );

  seed_rot_expander #(.W(W), .MIN_WT(4), .WT_RES(0)) dut_per (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b),
    .in_seed(in_seed), .out_valid(out_valid_b), .out_ready(out_ready),
    .out_lanes(lanes_b), .out_mask(mask_b)
  );

  function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int k);
    logic [W-1:0] r;
    for (int j = 0; j < W; j++) r[j] = v[(j + k) % W];
    return r;
  endfunction

  function automatic logic [W-1:0] exp_mask(input int c);
    if (c >= W) return '1;
    return (64'd1 << c) - 64'd1;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one seed for one cycle, then sample after the capturing edge
  task automatic send(input logic [W-1:0] s);
    @(negedge clk);
    in_valid = 1'b1;
    in_seed  = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [W-1:0] lane_err;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 in_ready", {63'd0, in_ready_a}, 64'd1);
    check("R8 out_valid", {63'd0, out_valid_a}, 64'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      send(VECS[v].seed);
      check("R1 out_valid", {63'd0, out_valid_a & out_valid_b}, 64'd1);
      check("R4/R5/R7 mask", mask_a, exp_mask(int'(VECS[v].cnt_a)));
      check("R6 periodic mask", mask_b, exp_mask(int'(VECS[v].cnt_b)));
      lane_err = '0;
      for (int i = 0; i < W; i++)
        lane_err[i] = (lanes_a[i*W +: W] !== rotr(VECS[v].seed, i));
      check("R3 lane rotation", lane_err, '0);
    end

    // R9 output drains when taken with no new seed
    @(negedge clk);
    check("R9 out_valid low", {63'd0, out_valid_a}, 64'd0);

    // R2 back-pressure
    out_ready = 1'b0;
    send(64'h0000_0000_0007_FFFF);
    in_valid = 1'b1;
    in_seed  = 64'h0000_0000_007F_FFFF;
    #1;
    check("R2 in_ready low", {63'd0, in_ready_a}, 64'd0);
    repeat (3) @(negedge clk);
    check("R2 lane0 held", lanes_a[W-1:0], 64'h0000_0000_0007_FFFF);
    check("R2 mask held", mask_a, '1);
    check("R2 out_valid held", {63'd0, out_valid_a}, 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 second seed after release", lanes_a[W-1:0], 64'h0000_0000_007F_FFFF);

    // R10 back-to-back acceptance
    @(negedge clk);
    in_valid = 1'b1;
    in_seed  = 64'h0000_0000_0000_0007;
    @(negedge clk);
    check("R10 first seed", lanes_a[W-1:0], 64'h0000_0000_0000_0007);
    in_seed = 64'h7FFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    check("R10 second seed", lanes_a[W-1:0], 64'h7FFF_FFFF_FFFF_FFFF);
    check("R10 second mask", mask_a, '1);
    in_seed = 64'h5555_5555_5555_5555;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 third seed", lanes_a[W-1:0], 64'h5555_5555_5555_5555);
    check("R10 third mask periodic", mask_b, 64'h3);
    @(negedge clk);
    check("R9 drained", {63'd0, out_valid_a}, 64'd0);

    summary();
  end
endmodule